// File: doc/BRIEF.md
# Posted Write Delivery Sequencer

This block is the initiator-side sequencer of a bus bridge that pushes buffered posted write data out to a target. It accepts a write from the posting buffer as a starting address, a command, and a DWORD count. The command is either a plain memory write or a memory-write-and-invalidate. The block then launches one bus attempt at a time and waits for the target's termination of that attempt.

A retry leaves the attempt unchanged. A disconnect moves the start address past the DWORDs already taken. If an invalidate-type write was only partly delivered, the block falls back to the plain write command for the rest. Every attempt that leaves data undelivered counts against a parameterised limit. When the limit is reached, the block drops the leftover data and may raise a system error request, subject to two configuration bits.

Top module: `pwr_sequencer`

## Requirements
- R1: `reqReady` is high only while no write is in progress. A write is taken when `reqValid` and `reqReady` are both high. The first attempt then presents the request's address, command and count. A `reqValid` seen while busy has no effect on the attempt.
- R2: After a retry termination (`termKind` = 1, or the unused code 3), the next attempt presents the same address, command and remaining count as the attempt that failed.
- R3: After a disconnect (`termKind` = 2) that reports `termXfer` DWORDs taken, the next attempt starts at the old address plus 4·`termXfer`, and its count is lower by `termXfer`.
- R4: The command encoding is 1 for memory-write-and-invalidate and 0 for plain memory write. After a disconnect with `termXfer` > 0, every later attempt of that write uses code 0. A disconnect with `termXfer` = 0 keeps the command.
- R5: A normal termination (`termKind` = 0) completes the write. So does a disconnect whose `termXfer` covers the remaining count. On completion, `writeDone` pulses for exactly one cycle and `reqReady` returns high.
- R6: Each terminated attempt that leaves data behind counts as a failure. The attempt that brings the count to `MAX_TRIES` ends the write instead of relaunching it. At that point `writeDiscard` pulses for one cycle and the block goes idle.
- R7: `serrReq` pulses together with `writeDiscard` only when `serrEnable` is 1 and `pwDropSerrMask` is 0. Otherwise it stays low.
- R8: The failure count restarts at zero whenever a new write is accepted.
- R9: `attemptStart` is a single-cycle pulse per attempt. No further attempt starts until the current one is terminated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Posting buffer offers a write |
| reqReady | output | 1 | Sequencer idle, write can be taken |
| reqAddr | input | ADDR_W | Start byte address of the write |
| reqInvalidate | input | 1 | 1 = memory-write-and-invalidate, 0 = memory write |
| reqCount | input | CNT_W | DWORDs to deliver |
| attemptStart | output | 1 | Launch pulse for one bus attempt |
| attemptAddr | output | ADDR_W | Start address of the current attempt |
| attemptInvalidate | output | 1 | Command of the current attempt |
| attemptCount | output | CNT_W | DWORDs still to deliver |
| termValid | input | 1 | Current attempt has been terminated |
| termKind | input | 2 | 0 normal, 1 retry, 2 disconnect, 3 treated as retry |
| termXfer | input | CNT_W | DWORDs accepted before a disconnect |
| serrEnable | input | 1 | System error reporting enabled |
| pwDropSerrMask | input | 1 | Masks the error for undelivered posted writes |
| writeDone | output | 1 | One-cycle pulse on complete delivery |
| writeDiscard | output | 1 | One-cycle pulse when leftover data is dropped |
| serrReq | output | 1 | One-cycle system error request |

## Verification
The bound checker watches several properties on every cycle. It checks that launches are single pulses and never occur while idle. It checks that a relaunch after a retry keeps its address, and that a relaunch after a disconnect advances the address by four bytes per DWORD taken. It checks the command fallback after a partial disconnect, that done and discard never coincide, and that an error request only appears with a discard under the right configuration. Only the bench scenarios can show whether the attempt limit lands on exactly the right attempt, and whether the failure count restarts with each new write. The same holds for `reqValid` being ignored mid-write and for each combination of the two gating bits.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    TERM_NORMAL = 2'd0,
    TERM_RETRY  = 2'd1,
    TERM_DISC   = 2'd2,
    TERM_RSVD   = 2'd3
  } termKind_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2
  } seqState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } pwrStrobe_t;
endpackage

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwrStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqInvalidate,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [1:0]        termKind,
  input  logic [CNT_W-1:0]  termXfer,
  output logic [ADDR_W-1:0] addrQ,
  output logic              invQ,
  output logic [CNT_W-1:0]  remQ,
  output logic              allSent
);
  localparam int BYTE_SHIFT = 2;

  logic [CNT_W-1:0]  delivered;
  logic [CNT_W-1:0]  newRem;
  logic [ADDR_W-1:0] byteStep;

  always_comb begin
    case (termKind)
      TERM_NORMAL: delivered = remQ;
      TERM_DISC:   delivered = (termXfer < remQ) ? termXfer : remQ;
      default:     delivered = '0;
    endcase
    newRem   = remQ - delivered;
    allSent  = (newRem == '0);
    byteStep = ADDR_W'({delivered, {BYTE_SHIFT{1'b0}}});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      invQ  <= 1'b0;
      remQ  <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      invQ  <= reqInvalidate;
      remQ  <= reqCount;
    end else if (strb.advance) begin
      addrQ <= addrQ + byteStep;
      remQ  <= newRem;
      if (termKind == TERM_DISC && delivered != '0) invQ <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_control.sv
module pwr_control
  import pwr_pkg::*;
#(
  parameter int MAX_TRIES = 1 << 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       termValid,
  input  logic       allSent,
  input  logic       serrEnable,
  input  logic       pwDropSerrMask,
  output pwrStrobe_t strb,
  output logic       reqReady,
  output logic       attemptStart,
  output logic       writeDone,
  output logic       writeDiscard,
  output logic       serrReq
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_FAIL = TRY_W'(MAX_TRIES - 1);

  seqState_e        stateQ;
  logic [TRY_W-1:0] failQ;

  assign reqReady     = (stateQ == ST_IDLE);
  assign attemptStart = (stateQ == ST_LAUNCH);

  always_comb begin
    strb.load    = reqReady && reqValid;
    strb.advance = (stateQ == ST_WAIT) && termValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      failQ        <= '0;
      writeDone    <= 1'b0;
      writeDiscard <= 1'b0;
      serrReq      <= 1'b0;
    end else begin
      writeDone    <= 1'b0;
      writeDiscard <= 1'b0;
      serrReq      <= 1'b0;
      case (stateQ)
        ST_IDLE: if (strb.load) begin
          failQ  <= '0;
          stateQ <= ST_LAUNCH;
        end
        ST_LAUNCH: stateQ <= ST_WAIT;
        ST_WAIT: if (strb.advance) begin
          if (allSent) begin
            writeDone <= 1'b1;
            stateQ    <= ST_IDLE;
          end else if (failQ == LAST_FAIL) begin
            writeDiscard <= 1'b1;
            serrReq      <= serrEnable && !pwDropSerrMask;
            stateQ       <= ST_IDLE;
          end else begin
            failQ  <= failQ + 1'b1;
            stateQ <= ST_LAUNCH;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_sequencer.sv
module pwr_sequencer
  import pwr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 8,
  parameter int MAX_TRIES = 1 << 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqInvalidate,
  input  logic [CNT_W-1:0]  reqCount,
  output logic              attemptStart,
  output logic [ADDR_W-1:0] attemptAddr,
  output logic              attemptInvalidate,
  output logic [CNT_W-1:0]  attemptCount,
  input  logic              termValid,
  input  logic [1:0]        termKind,
  input  logic [CNT_W-1:0]  termXfer,
  input  logic              serrEnable,
  input  logic              pwDropSerrMask,
  output logic              writeDone,
  output logic              writeDiscard,
  output logic              serrReq
);
  pwrStrobe_t strb;
  logic       allSent;

  pwr_control #(.MAX_TRIES(MAX_TRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .termValid(termValid),
    .allSent(allSent), .serrEnable(serrEnable), .pwDropSerrMask(pwDropSerrMask),
    .strb(strb), .reqReady(reqReady), .attemptStart(attemptStart),
    .writeDone(writeDone), .writeDiscard(writeDiscard), .serrReq(serrReq)
  );

  pwr_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr),
    .reqInvalidate(reqInvalidate), .reqCount(reqCount), .termKind(termKind),
    .termXfer(termXfer), .addrQ(attemptAddr), .invQ(attemptInvalidate),
    .remQ(attemptCount), .allSent(allSent)
  );
endmodule

// File: rtl/pwr_checker.sv
module pwr_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              attemptStart,
  input logic [ADDR_W-1:0] attemptAddr,
  input logic              attemptInvalidate,
  input logic              termValid,
  input logic [1:0]        termKind,
  input logic [CNT_W-1:0]  termXfer,
  input logic              serrEnable,
  input logic              pwDropSerrMask,
  input logic              writeDone,
  input logic              writeDiscard,
  input logic              serrReq
);
  assert_idle_no_launch_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !attemptStart);

  assert_retry_same_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (attemptStart && !$past(reqReady) && $past(termValid) && $past(termKind) == 2'd1)
      |-> attemptAddr == $past(attemptAddr));

  assert_disc_resume_R3: assert property (@(posedge clk) disable iff (!rstN)
    (attemptStart && !$past(reqReady) && $past(termValid) && $past(termKind) == 2'd2)
      |-> attemptAddr == $past(attemptAddr) + ADDR_W'({$past(termXfer), 2'b00}));

  assert_downgrade_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (attemptStart && !$past(reqReady) && $past(termValid) && $past(termKind) == 2'd2
      && $past(termXfer) != '0) |-> !attemptInvalidate);

  assert_end_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(writeDone && writeDiscard));

  assert_serr_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    serrReq |-> (writeDiscard && $past(serrEnable) && !$past(pwDropSerrMask)));

  assert_launch_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    attemptStart |=> !attemptStart);
endmodule

bind pwr_sequencer pwr_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .attemptStart(attemptStart),
  .attemptAddr(attemptAddr), .attemptInvalidate(attemptInvalidate),
  .termValid(termValid), .termKind(termKind), .termXfer(termXfer),
  .serrEnable(serrEnable), .pwDropSerrMask(pwDropSerrMask),
  .writeDone(writeDone), .writeDiscard(writeDiscard), .serrReq(serrReq)
);

// File: tb/pwr_sequencer_bench.sv
module pwr_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int TRIES  = 4;

  // end codes: 0 none, 1 done, 2 discard
  typedef struct packed {
    logic        newReq;
    logic [31:0] rAddr;
    logic        rInv;
    logic [7:0]  rCnt;
    logic [31:0] eAddr;
    logic        eInv;
    logic [7:0]  eRem;
    logic [1:0]  kind;
    logic [7:0]  xfer;
    logic [1:0]  eEnd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t TBL [NVEC] = '{
    '{1'b1, 32'h1000, 1'b1, 8'd8, 32'h1000, 1'b1, 8'd8, 2'd1, 8'd0, 2'd0},
    '{1'b0, 32'h0,    1'b0, 8'd0, 32'h1000, 1'b1, 8'd8, 2'd2, 8'd3, 2'd0},
    '{1'b0, 32'h0,    1'b0, 8'd0, 32'h100C, 1'b0, 8'd5, 2'd1, 8'd0, 2'd0},
    '{1'b0, 32'h0,    1'b0, 8'd0, 32'h100C, 1'b0, 8'd5, 2'd0, 8'd0, 2'd1},
    '{1'b1, 32'h2000, 1'b1, 8'd6, 32'h2000, 1'b1, 8'd6, 2'd2, 8'd0, 2'd0},
    '{1'b0, 32'h0,    1'b0, 8'd0, 32'h2000, 1'b1, 8'd6, 2'd2, 8'd6, 2'd1},
    '{1'b1, 32'h3000, 1'b0, 8'd4, 32'h3000, 1'b0, 8'd4, 2'd3, 8'd0, 2'd0},
    '{1'b0, 32'h0,    1'b0, 8'd0, 32'h3000, 1'b0, 8'd4, 2'd2, 8'd9, 2'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqInvalidate = 1'b0;
  logic [CNT_W-1:0] reqCount = '0;
  logic attemptStart;
  logic [ADDR_W-1:0] attemptAddr;
  logic attemptInvalidate;
  logic [CNT_W-1:0] attemptCount;
  logic termValid = 1'b0;
  logic [1:0] termKind = '0;
  logic [CNT_W-1:0] termXfer = '0;
  logic serrEnable = 1'b1;
  logic pwDropSerrMask = 1'b0;
  logic writeDone, writeDiscard, serrReq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_TRIES(TRIES)) u_pwr_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqInvalidate(reqInvalidate), .reqCount(reqCount),
    .attemptStart(attemptStart), .attemptAddr(attemptAddr),
    .attemptInvalidate(attemptInvalidate), .attemptCount(attemptCount),
    .termValid(termValid), .termKind(termKind), .termXfer(termXfer),
    .serrEnable(serrEnable), .pwDropSerrMask(pwDropSerrMask),
    .writeDone(writeDone), .writeDiscard(writeDiscard), .serrReq(serrReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issueReq(input logic [31:0] a, input logic inv, input logic [7:0] n);
    @(negedge clk);
    chk("R1 ready before request", {31'd0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = a; reqInvalidate = inv; reqCount = n;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitStart(input string req);
    int n = 0;
    while (attemptStart !== 1'b1 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'd0, attemptStart}, 32'd1);
  endtask

  // called at the negedge where attemptStart is high; returns at the negedge
  // where the end pulses of this termination are visible
  task automatic applyTerm(input logic [1:0] k, input logic [7:0] x);
    @(negedge clk);
    chk("R9 single launch pulse", {31'd0, attemptStart}, 32'd0);
    termValid = 1'b1; termKind = k; termXfer = x;
    @(negedge clk);
    termValid = 1'b0;
  endtask

  task automatic checkEnd(input string req, input logic [1:0] e, input logic s);
    chk(req, {29'd0, serrReq, writeDiscard, writeDone},
        {29'd0, s, e == 2'd2, e == 2'd1});
  endtask

  task automatic failRun(input logic en, input logic msk, input logic expSerr);
    serrEnable = en; pwDropSerrMask = msk;
    issueReq(32'h5000, 1'b0, 8'd2);
    for (int i = 0; i < TRIES - 1; i++) begin
      waitStart("R6 relaunch below limit");
      applyTerm(2'd1, 8'd0);
      checkEnd("R6 no end before limit", 2'd0, 1'b0);
    end
    waitStart("R6 last attempt");
    applyTerm(2'd1, 8'd0);
    checkEnd("R6/R7 discard and gated error", 2'd2, expSerr);
    @(negedge clk);
    chk("R6 discard single pulse, idle", {30'd0, writeDiscard, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", {28'd0, reqReady, attemptStart, writeDone, writeDiscard}, 32'h8);
    chk("R7 reset serr", {31'd0, serrReq}, 32'd0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      if (TBL[v].newReq) issueReq(TBL[v].rAddr, TBL[v].rInv, TBL[v].rCnt);
      waitStart("R9 attempt launched");
      chk("R1/R2/R3 attempt address", attemptAddr, TBL[v].eAddr);
      chk("R4 attempt command", {31'd0, attemptInvalidate}, {31'd0, TBL[v].eInv});
      chk("R3 attempt count", {24'd0, attemptCount}, {24'd0, TBL[v].eRem});
      applyTerm(TBL[v].kind, TBL[v].xfer);
      checkEnd("R5 termination outcome", TBL[v].eEnd, 1'b0);
      if (TBL[v].eEnd == 2'd1) begin
        @(negedge clk);
        chk("R5 done single pulse, idle", {30'd0, writeDone, reqReady}, 32'd1);
      end
    end

    // R1: request while busy is ignored
    issueReq(32'h7000, 1'b1, 8'd3);
    waitStart("R1 launch");
    reqValid = 1'b1; reqAddr = 32'hDEAD0; reqInvalidate = 1'b0; reqCount = 8'd1;
    chk("R1 not ready while busy", {31'd0, reqReady}, 32'd0);
    applyTerm(2'd1, 8'd0);
    reqValid = 1'b0;
    waitStart("R1 relaunch");
    chk("R1 busy request ignored addr", attemptAddr, 32'h7000);
    chk("R1 busy request ignored count", {24'd0, attemptCount}, 32'd3);
    applyTerm(2'd0, 8'd0);
    checkEnd("R5 done", 2'd1, 1'b0);

    // R6/R7 limit with each gating combination
    failRun(1'b1, 1'b0, 1'b1);
    failRun(1'b0, 1'b0, 1'b0);
    failRun(1'b1, 1'b1, 1'b0);
    serrEnable = 1'b1; pwDropSerrMask = 1'b0;

    // R8: failure count restarts with a new write
    for (int w = 0; w < 2; w++) begin
      issueReq(32'h9000, 1'b0, 8'd2);
      for (int i = 0; i < TRIES - 1; i++) begin
        waitStart("R8 relaunch");
        applyTerm(2'd1, 8'd0);
        checkEnd("R8 no discard after count restart", 2'd0, 1'b0);
      end
      waitStart("R8 final attempt");
      applyTerm(2'd0, 8'd0);
      checkEnd("R8 completes", 2'd1, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule